// File: doc/BRIEF.md
# Transactional State Tracking Controller

This block keeps the transactional-memory view of a processor's machine state: a TM-enable bit and a two-bit transaction state. It also keeps a checkpointed begin address and an eight-bit failure cause. The surrounding pipeline presents at most one event per clock: begin, end, suspend, resume, abort (conflict, signal delivery or context switch), exception entry, or return-from-interrupt. A return-from-interrupt also stands for a direct write of the state register. The block updates its state on the next clock edge.

When a running or suspended transaction is aborted, the block raises a one-cycle rollback request. The request carries the restart address, which is the checkpointed begin address plus one instruction, so the branch after the begin sends control to the failure handler. The abort reason is kept in the cause register. Restoring registers and memory is left to the rest of the core; this block only asks for the rollback. A mode input makes suspend requests and exception entries abort the transaction instead of suspending it.

Top module: `txn_state_ctrl`

## Requirements
- R1: After a synchronous reset, the enable bit is 0, the state is 00, the cause is 0, no rollback is requested and the restart address reads 0.
- R2: The state is encoded as 00 non-transactional, 01 suspended and 10 transactional. The code 11 is never held. A return-from-interrupt that requests 11 leaves the enable bit and the state unchanged.
- R3: A begin event (op 1) with enable set and state 00 moves to 10 and latches the event address as the checkpoint. A begin with enable clear, or in any other state, is ignored.
- R4: An end event (op 2) in state 10 returns to 00 with no rollback. An end event in state 00 or 01 is ignored.
- R5: A suspend event (op 3) in state 10 moves to 01 when the abort mode is off. A resume event (op 4) in state 01 moves to 10. Both events are ignored in any other state.
- R6: An abort event (op 5) in state 10 or 01 raises the rollback output for exactly the one cycle after the event, with the restart address equal to checkpoint + 4. In that same cycle the state is 00 and the cause holds the event's cause input. An abort in state 00 is ignored, and the cause changes only with a rollback.
- R7: The restart address output is 0 in every cycle without a rollback.
- R8: The persistent flag output equals bit 7 of the cause register.
- R9: With the abort mode off, exception entry (op 6) clears the enable bit, turns state 10 into 01, and leaves other states unchanged.
- R10: A return-from-interrupt (op 7) copies the requested field into the live state, where field bits [2:1] are the state and bit 0 is the enable bit.
- R11: When the live field is 3'b010 (enable off, suspended) and the requested field is 3'b000, a return-from-interrupt leaves the live field unchanged.
- R12: With the abort mode on, a suspend in state 10 rolls back with cause 8'h81. An exception entry in state 10 rolls back with cause 8'h02 and keeps the enable bit. Both go to state 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_op_i | input | 3 | Event code: 0 none, 1 begin, 2 end, 3 suspend, 4 resume, 5 abort, 6 exception entry, 7 return-from-interrupt |
| evt_addr_i | input | 32 | Address of the begin instruction (begin events) |
| evt_cause_i | input | 8 | Failure cause for abort events |
| evt_field_i | input | 3 | Requested {state[1:0], enable} for return-from-interrupt |
| abort_on_suspend_i | input | 1 | Mode: suspend and exception entry abort the transaction |
| tm_en_o | output | 1 | Live TM-enable bit |
| tx_state_o | output | 2 | Live transaction state |
| rollback_o | output | 1 | One-cycle rollback request |
| restart_addr_o | output | 32 | Restart address, valid with rollback_o, else 0 |
| fail_cause_o | output | 8 | Last abort cause |
| fail_persistent_o | output | 1 | Cause marked persistent |

## Verification
The embedded properties watch, on every cycle, that the reserved state code never appears and that a rollback lasts one cycle and coincides with state 00. They also check that the cause moves only with a rollback, that a begin with enable clear leaves the state alone, that exception entry in normal mode clears the enable bit, and that the suspended-to-non-transactional return is refused. The restart address arithmetic, the latched cause values and the persistent flag are shown only by the bench's scenarios. So are the exact transitions of each event in each state, the field layout of the return-from-interrupt and both abort-mode paths. The bench's reference model predicts these cycle by cycle.

// File: rtl/txn_state_pkg.sv
// Package: shared encodings for the transactional state controller.
// Assumes one event per cycle, carried as a 3-bit code.
package txn_state_pkg;

    typedef enum logic [1:0] {
        TS_NONTX = 2'b00,
        TS_SUSP  = 2'b01,
        TS_TRANS = 2'b10,
        TS_RSVD  = 2'b11
    } ts_e;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_BEGIN   = 3'd1,
        EV_END     = 3'd2,
        EV_SUSPEND = 3'd3,
        EV_RESUME  = 3'd4,
        EV_ABORT   = 3'd5,
        EV_EXCEPT  = 3'd6,
        EV_RETURN  = 3'd7
    } ev_e;

    // Live field layout {state, enable}; the return rule depends on it.
    typedef struct packed {
        ts_e  st;
        logic en;
    } live_t;

    localparam live_t LIVE_RESET = '{st: TS_NONTX, en: 1'b0};

    // True for the one return that must not leave suspend.
    function automatic logic keep_suspend(input live_t cur, input live_t req);
        return ({cur.st, cur.en} == 3'b010) && ({req.st, req.en} == 3'b000);
    endfunction

endpackage

// File: rtl/txn_evt_decode.sv
// Module: txn_evt_decode
// Purely combinational next-state decoder. Given the live field and the
// event of this cycle, it computes the next live field, the checkpoint
// write, the rollback request and the cause update.
// Assumes at most one event per cycle and registered state outside.
module txn_evt_decode
    import txn_state_pkg::*;
#(
    parameter int           CAUSE_W          = 8,
    parameter logic [7:0]   SUSP_ABORT_CAUSE = 8'h81,
    parameter logic [7:0]   EXC_ABORT_CAUSE  = 8'h02
) (
    input  live_t               cur_i,
    input  ev_e                 op_i,
    input  live_t               req_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic                abort_mode_i,
    output live_t               nxt_o,
    output logic                ckpt_we_o,
    output logic                rb_req_o,
    output logic [CAUSE_W-1:0]  cause_val_o
);

    // Event decode: one case arm per event, anything unlisted holds state.
    always_comb begin
        nxt_o       = cur_i;
        ckpt_we_o   = 1'b0;
        rb_req_o    = 1'b0;
        cause_val_o = cause_i;
        unique case (op_i)
            EV_BEGIN: begin
                if (cur_i.en && cur_i.st == TS_NONTX) begin
                    nxt_o.st  = TS_TRANS;
                    ckpt_we_o = 1'b1;
                end
            end
            EV_END: begin
                if (cur_i.st == TS_TRANS) nxt_o.st = TS_NONTX;
            end
            EV_SUSPEND: begin
                if (cur_i.st == TS_TRANS) begin
                    if (abort_mode_i) begin
                        rb_req_o    = 1'b1;
                        cause_val_o = CAUSE_W'(SUSP_ABORT_CAUSE);
                        nxt_o.st    = TS_NONTX;
                    end else begin
                        nxt_o.st = TS_SUSP;
                    end
                end
            end
            EV_RESUME: begin
                if (cur_i.st == TS_SUSP) nxt_o.st = TS_TRANS;
            end
            EV_ABORT: begin
                if (cur_i.st == TS_TRANS || cur_i.st == TS_SUSP) begin
                    rb_req_o = 1'b1;
                    nxt_o.st = TS_NONTX;
                end
            end
            EV_EXCEPT: begin
                if (abort_mode_i && cur_i.st == TS_TRANS) begin
                    rb_req_o    = 1'b1;
                    cause_val_o = CAUSE_W'(EXC_ABORT_CAUSE);
                    nxt_o.st    = TS_NONTX;
                end else begin
                    nxt_o.en = 1'b0;
                    if (cur_i.st == TS_TRANS) nxt_o.st = TS_SUSP;
                end
            end
            EV_RETURN: begin
                if (req_i.st != TS_RSVD && !keep_suspend(cur_i, req_i))
                    nxt_o = req_i;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/txn_live_reg.sv
// Module: txn_live_reg
// Holds the live enable bit and transaction state.
// Assumes the decoder never proposes the reserved state code.
module txn_live_reg
    import txn_state_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  live_t nxt_i,
    output live_t live_o
);

    // Live field register with synchronous reset to non-transactional, off.
    always_ff @(posedge clk) begin
        if (!rst_n) live_o <= LIVE_RESET;
        else        live_o <= nxt_i;
    end

    AST_NO_RSVD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        live_o.st != TS_RSVD); // R2

endmodule

// File: rtl/txn_rollback_unit.sv
// Module: txn_rollback_unit
// Keeps the checkpoint address and the failure cause, and produces the
// registered rollback pulse with its restart address.
// Assumes a begin and a rollback never happen in the same cycle.
module txn_rollback_unit #(
    parameter int ADDR_W     = 32,
    parameter int CAUSE_W    = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ckpt_we_i,
    input  logic [ADDR_W-1:0]  ckpt_addr_i,
    input  logic               rb_req_i,
    input  logic [CAUSE_W-1:0] cause_val_i,
    output logic               rb_o,
    output logic [ADDR_W-1:0]  restart_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] ckpt_q;

    // Checkpoint: latch the begin address when a transaction starts.
    always_ff @(posedge clk) begin
        if (!rst_n)         ckpt_q <= '0;
        else if (ckpt_we_i) ckpt_q <= ckpt_addr_i;
    end

    // Rollback pulse and restart address, zero outside the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_o      <= 1'b0;
            restart_o <= '0;
        end else begin
            rb_o      <= rb_req_i;
            restart_o <= rb_req_i ? ckpt_q + STEP : '0;
        end
    end

    // Failure cause: recorded only by an abort that rolls back.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause_o <= '0;
        else if (rb_req_i) cause_o <= cause_val_i;
    end

    AST_CAUSE_ONLY_ON_RB: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_o |-> $stable(cause_o)); // R6

endmodule

// File: rtl/txn_state_ctrl.sv
// Module: txn_state_ctrl (top)
// Tracks transactional state for one hardware thread: decodes one event
// per cycle, updates the live field, and requests rollback on aborts.
// Assumes events arrive synchronously and are valid for one cycle each.
module txn_state_ctrl
    import txn_state_pkg::*;
#(
    parameter int         ADDR_W           = 32,
    parameter int         CAUSE_W          = 8,
    parameter int         INSN_BYTES       = 4,
    parameter logic [7:0] SUSP_ABORT_CAUSE = 8'h81,
    parameter logic [7:0] EXC_ABORT_CAUSE  = 8'h02
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         evt_op_i,
    input  logic [ADDR_W-1:0]  evt_addr_i,
    input  logic [CAUSE_W-1:0] evt_cause_i,
    input  logic [2:0]         evt_field_i,
    input  logic               abort_on_suspend_i,
    output logic               tm_en_o,
    output logic [1:0]         tx_state_o,
    output logic               rollback_o,
    output logic [ADDR_W-1:0]  restart_addr_o,
    output logic [CAUSE_W-1:0] fail_cause_o,
    output logic               fail_persistent_o
);

    localparam int PERSIST_BIT = CAUSE_W - 1;

    live_t              live_q;
    live_t              live_nxt;
    logic               ckpt_we;
    logic               rb_req;
    logic [CAUSE_W-1:0] cause_val;

    txn_evt_decode #(
        .CAUSE_W         (CAUSE_W),
        .SUSP_ABORT_CAUSE(SUSP_ABORT_CAUSE),
        .EXC_ABORT_CAUSE (EXC_ABORT_CAUSE)
    ) u_decode (
        .cur_i       (live_q),
        .op_i        (ev_e'(evt_op_i)),
        .req_i       (live_t'(evt_field_i)),
        .cause_i     (evt_cause_i),
        .abort_mode_i(abort_on_suspend_i),
        .nxt_o       (live_nxt),
        .ckpt_we_o   (ckpt_we),
        .rb_req_o    (rb_req),
        .cause_val_o (cause_val)
    );

    txn_live_reg u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_i (live_nxt),
        .live_o(live_q)
    );

    txn_rollback_unit #(
        .ADDR_W    (ADDR_W),
        .CAUSE_W   (CAUSE_W),
        .INSN_BYTES(INSN_BYTES)
    ) u_rollback (
        .clk        (clk),
        .rst_n      (rst_n),
        .ckpt_we_i  (ckpt_we),
        .ckpt_addr_i(evt_addr_i),
        .rb_req_i   (rb_req),
        .cause_val_i(cause_val),
        .rb_o       (rollback_o),
        .restart_o  (restart_addr_o),
        .cause_o    (fail_cause_o)
    );

    assign tm_en_o           = live_q.en;
    assign tx_state_o        = live_q.st;
    assign fail_persistent_o = fail_cause_o[PERSIST_BIT];

    AST_RB_IN_NONTX: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |-> tx_state_o == 2'b00); // R6

    AST_RB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |=> !rollback_o); // R6

    AST_BEGIN_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(evt_op_i) == 3'd1 && !$past(tm_en_o))
        |-> $stable(tx_state_o)); // R3

    AST_EXC_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(evt_op_i) == 3'd6 && !$past(abort_on_suspend_i))
        |-> !tm_en_o); // R9

    AST_SUSP_HELD_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(evt_op_i) == 3'd7
         && $past({tx_state_o, tm_en_o}) == 3'b010 && $past(evt_field_i) == 3'b000)
        |-> {tx_state_o, tm_en_o} == 3'b010); // R11

endmodule

// File: tb/sim_txn_state_ctrl.sv
// Scoreboard bench: a driver task applies one event per cycle and pushes
// the predicted outputs; a monitor pops and compares after each edge.
module sim_txn_state_ctrl;

    localparam logic [2:0] OP_NONE = 3'd0, OP_BEGIN = 3'd1, OP_END = 3'd2,
                           OP_SUSP = 3'd3, OP_RES = 3'd4, OP_ABORT = 3'd5,
                           OP_EXC = 3'd6, OP_RET = 3'd7;
    localparam logic [7:0] SUSP_C = 8'h81;
    localparam logic [7:0] EXC_C  = 8'h02;

    typedef struct packed {
        logic        en;
        logic [1:0]  st;
        logic        rb;
        logic [31:0] addr;
        logic [7:0]  cz;
        logic        pers;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_op = '0;
    logic [31:0] evt_addr = '0;
    logic [7:0]  evt_cause = '0;
    logic [2:0]  evt_field = '0;
    logic        mode = 1'b0;
    logic        tm_en;
    logic [1:0]  tx_state;
    logic        rollback;
    logic [31:0] restart_addr;
    logic [7:0]  fail_cause;
    logic        fail_pers;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state
    logic        m_en = 1'b0;
    logic [1:0]  m_st = 2'b00;
    logic [31:0] m_ck = '0;
    logic [7:0]  m_cz = '0;

    always #2.5 clk = ~clk;

    txn_state_ctrl u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .evt_op_i          (evt_op),
        .evt_addr_i        (evt_addr),
        .evt_cause_i       (evt_cause),
        .evt_field_i       (evt_field),
        .abort_on_suspend_i(mode),
        .tm_en_o           (tm_en),
        .tx_state_o        (tx_state),
        .rollback_o        (rollback),
        .restart_addr_o    (restart_addr),
        .fail_cause_o      (fail_cause),
        .fail_persistent_o (fail_pers)
    );

    task automatic check(input string tag, input exp_t act, input exp_t exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual en=%b st=%b rb=%b addr=%h cause=%h pers=%b expected en=%b st=%b rb=%b addr=%h cause=%h pers=%b",
                     tag, act.en, act.st, act.rb, act.addr, act.cz, act.pers,
                     exp.en, exp.st, exp.rb, exp.addr, exp.cz, exp.pers);
        end
    endtask

    function automatic exp_t sample();
        exp_t s;
        s.en = tm_en; s.st = tx_state; s.rb = rollback;
        s.addr = restart_addr; s.cz = fail_cause; s.pers = fail_pers;
        return s;
    endfunction

    // Driver: apply one event at the falling edge and predict its outcome.
    task automatic send(input logic [2:0] op, input logic [31:0] pc,
                        input logic [7:0] cz, input logic [2:0] fld, input string tag);
        exp_t e;
        logic rb;
        rb = 1'b0;
        @(negedge clk);
        evt_op = op; evt_addr = pc; evt_cause = cz; evt_field = fld;
        case (op)
            OP_BEGIN: if (m_en && m_st == 2'b00) begin m_st = 2'b10; m_ck = pc; end
            OP_END:   if (m_st == 2'b10) m_st = 2'b00;
            OP_SUSP:  if (m_st == 2'b10) begin
                          if (mode) begin rb = 1'b1; m_cz = SUSP_C; m_st = 2'b00; end
                          else m_st = 2'b01;
                      end
            OP_RES:   if (m_st == 2'b01) m_st = 2'b10;
            OP_ABORT: if (m_st != 2'b00) begin rb = 1'b1; m_cz = cz; m_st = 2'b00; end
            OP_EXC:   if (mode && m_st == 2'b10) begin
                          rb = 1'b1; m_cz = EXC_C; m_st = 2'b00;
                      end else begin
                          m_en = 1'b0;
                          if (m_st == 2'b10) m_st = 2'b01;
                      end
            OP_RET:   if (fld[2:1] != 2'b11 && !({m_st, m_en} == 3'b010 && fld == 3'b000))
                          {m_st, m_en} = fld;
            default: ;
        endcase
        e.en = m_en; e.st = m_st; e.rb = rb;
        e.addr = rb ? m_ck + 32'd4 : 32'd0;
        e.cz = m_cz; e.pers = m_cz[7];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: after each rising edge compare the pending prediction.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, sample(), e);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_t r0;
        r0 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", sample(), r0);
        rst_n = 1'b1;

        send(OP_BEGIN, 32'h0000_0F00, 8'h00, 3'b000, "R3 begin while disabled");
        send(OP_RET,   32'h0, 8'h00, 3'b001, "R10 return enables");
        send(OP_BEGIN, 32'h0000_1000, 8'h00, 3'b000, "R3 begin");
        send(OP_BEGIN, 32'h0000_2000, 8'h00, 3'b000, "R3 begin while transactional");
        send(OP_END,   32'h0, 8'h00, 3'b000, "R4 end");
        send(OP_END,   32'h0, 8'h00, 3'b000, "R4 end while non-transactional");
        send(OP_BEGIN, 32'h0000_1100, 8'h00, 3'b000, "R3 begin again");
        send(OP_SUSP,  32'h0, 8'h00, 3'b000, "R5 suspend");
        send(OP_END,   32'h0, 8'h00, 3'b000, "R4 end while suspended");
        send(OP_SUSP,  32'h0, 8'h00, 3'b000, "R5 suspend while suspended");
        send(OP_RES,   32'h0, 8'h00, 3'b000, "R5 resume");
        send(OP_RES,   32'h0, 8'h00, 3'b000, "R5 resume while transactional");
        send(OP_ABORT, 32'h0, 8'h01, 3'b000, "R6 abort transient");
        send(OP_NONE,  32'h0, 8'h00, 3'b000, "R7 idle after rollback");
        send(OP_ABORT, 32'h0, 8'h55, 3'b000, "R6 abort while non-transactional");
        send(OP_BEGIN, 32'h0000_2000, 8'h00, 3'b000, "R3 begin");
        send(OP_EXC,   32'h0, 8'h00, 3'b000, "R9 exception in transaction");
        send(OP_RET,   32'h0, 8'h00, 3'b000, "R11 return keeps suspend");
        send(OP_RET,   32'h0, 8'h00, 3'b111, "R2 reserved state request");
        send(OP_ABORT, 32'h0, 8'h8A, 3'b000, "R8 persistent abort from suspend");
        send(OP_RET,   32'h0, 8'h00, 3'b001, "R10 return enables");
        send(OP_EXC,   32'h0, 8'h00, 3'b000, "R9 exception while non-transactional");
        send(OP_RET,   32'h0, 8'h00, 3'b011, "R10 return to suspended enabled");
        send(OP_RET,   32'h0, 8'h00, 3'b000, "R11 quirk only when enable off");
        send(OP_RET,   32'h0, 8'h00, 3'b001, "R10 return enables");
        send(OP_RES,   32'h0, 8'h00, 3'b000, "R5 resume while non-transactional");

        mode = 1'b1;
        send(OP_BEGIN, 32'h0000_3000, 8'h00, 3'b000, "R12 begin in abort mode");
        send(OP_SUSP,  32'h0, 8'h00, 3'b000, "R12 suspend aborts");
        send(OP_BEGIN, 32'h0000_3100, 8'h00, 3'b000, "R12 begin in abort mode");
        send(OP_EXC,   32'h0, 8'h00, 3'b000, "R12 exception aborts");
        send(OP_EXC,   32'h0, 8'h00, 3'b000, "R12 exception outside transaction");
        mode = 1'b0;
        send(OP_RET,   32'h0, 8'h00, 3'b001, "R10 return enables");

        for (int i = 0; i < 6; i++) begin
            send(OP_BEGIN, 32'h0001_0000 + 32'(i) * 32'h124, 8'h00, 3'b000, "R3 begin sweep");
            if (i % 2 == 1) send(OP_SUSP, 32'h0, 8'h00, 3'b000, "R5 suspend sweep");
            send(OP_ABORT, 32'h0, 8'(8'h10 + i * 8'h2F), 3'b000, "R6 abort sweep");
            send(OP_NONE,  32'h0, 8'h00, 3'b000, "R7 idle sweep");
        end
        send(OP_NONE, 32'h0, 8'h00, 3'b000, "R7 final idle");

        repeat (3) @(posedge clk);
        #2;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule